// File: doc/BRIEF.md
# Battery Thermistor Window Qualifier

This block takes a digitised reading of a battery thermistor divider, expressed as a fraction of the bias supply, and decides three things. It reports whether temperature qualification has been switched off, because the sense line is tied near ground. It reports whether a battery is attached, which is judged by the line floating near the bias rail. It reports whether the pack temperature is inside the allowed window, using an upper and a lower limit. Readings arrive as ADC codes with a one-cycle valid strobe, at whatever rate the converter produces them. A separate one-cycle millisecond tick drives the debounce timing.

A low reading means a hot pack and a high reading means a cold pack. The hot and cold limits each have their own latch with hysteresis, so a fault clears only after the reading has moved back past its limit by the hysteresis margin. Every output has its own debounce filter. A new raw value is adopted only after it has stayed unchanged for a fixed number of millisecond ticks (12 by default), and any change in the raw value restarts that count. Every threshold is a parameter given in ADC codes relative to full scale, which equals the bias supply.

Top module: `batt_therm_qual`

## Requirements
- R1: While reset is held, and after it until a filter's first debounce interval completes, `temp_ok`, `batt_present` and `therm_off` are 0.
- R2: A sampled code below HOT_TH (default 358, 35% of full scale) latches the too-hot condition, and `temp_ok` then goes to 0.
- R3: Once too-hot is latched, it stays latched for codes below HOT_TH+HYS (default 395). A code of at least 395 clears it.
- R4: A sampled code above COLD_TH (default 767, 75%) latches the too-cold condition, and `temp_ok` then goes to 0.
- R5: Once too-cold is latched, it stays latched for codes above COLD_TH-HYS (default 730). A code of at most 730 clears it.
- R6: A sampled code above GONE_TH (default 972, 95%) makes `batt_present` 0. Any lower code makes it 1.
- R7: A sampled code below OFF_TH (default 51, 5%) makes `therm_off` 1 and forces `temp_ok` to 1, whatever the state of the hot and cold latches.
- R8: An output takes a new raw value only on the HOLD_MS-th millisecond tick (default 12) over which that raw value has stayed unchanged. A change in the raw value before then restarts the count, and outputs change only on cycles that follow a tick.
- R9: `code` is taken only in cycles where `sample_vld` is 1. At all other times it has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_vld | input | 1 | One-cycle strobe marking a new ADC code |
| code | input | CODE_W | Divider reading; full scale equals the bias supply |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| temp_ok | output | 1 | Debounced: temperature in window, or qualification off |
| batt_present | output | 1 | Debounced: battery attached |
| therm_off | output | 1 | Debounced: thermistor input tied low, qualification off |

## Verification
The assertions check on every cycle that a code past the hot or cold limit sets its latch, and that a latch holds while the reading sits inside the hysteresis band. They also check that the latches move only on valid samples and that no output changes except on the cycle after a millisecond tick. The bench scenarios are needed for the rest. They show the exact tick on which each output settles, that a short excursion restarts the debounce count and never reaches an output, that removal and disable readings give the right output values, and that the outputs stay low after reset until a reading has been held long enough.

// File: rtl/batt_therm_qual.sv
module batt_therm_qual #(
  parameter int CODE_W  = 10,
  parameter int HOT_TH  = 358,
  parameter int COLD_TH = 767,
  parameter int GONE_TH = 972,
  parameter int OFF_TH  = 51,
  parameter int HYS     = 37,
  parameter int HOLD_MS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_vld,
  input  logic [CODE_W-1:0] code,
  input  logic              ms_tick,
  output logic              temp_ok,
  output logic              batt_present,
  output logic              therm_off
);

  localparam int CNT_W = $clog2(HOLD_MS + 1);
  localparam logic [CODE_W-1:0] HOT_C   = CODE_W'(HOT_TH);
  localparam logic [CODE_W-1:0] HOT_REL = CODE_W'(HOT_TH + HYS);
  localparam logic [CODE_W-1:0] COLD_C  = CODE_W'(COLD_TH);
  localparam logic [CODE_W-1:0] COLD_REL = CODE_W'(COLD_TH - HYS);
  localparam logic [CODE_W-1:0] GONE_C  = CODE_W'(GONE_TH);
  localparam logic [CODE_W-1:0] OFF_C   = CODE_W'(OFF_TH);
  localparam logic [CNT_W-1:0]  LAST    = CNT_W'(HOLD_MS - 1);

  logic [CODE_W-1:0] cur;
  logic              have, hot_lat, cold_lat;
  logic [2:0]        raw, filt, cand;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur      <= '0;
      have     <= 1'b0;
      hot_lat  <= 1'b0;
      cold_lat <= 1'b0;
    end else if (sample_vld) begin
      cur  <= code;
      have <= 1'b1;
      if (code < HOT_C)          hot_lat <= 1'b1;
      else if (code >= HOT_REL)  hot_lat <= 1'b0;
      if (code > COLD_C)         cold_lat <= 1'b1;
      else if (code <= COLD_REL) cold_lat <= 1'b0;
    end
  end

  wire off_now = cur < OFF_C;
  assign raw = have ? {off_now, !(cur > GONE_C), off_now | (!hot_lat & !cold_lat)} : 3'b000;

  for (genvar i = 0; i < 3; i++) begin : g_dg
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        filt[i] <= 1'b0;
        cand[i] <= 1'b0;
        cnt     <= '0;
      end else if (raw[i] != cand[i] || raw[i] == filt[i]) begin
        cand[i] <= raw[i];
        cnt     <= '0;
      end else if (ms_tick) begin
        if (cnt == LAST) begin
          filt[i] <= cand[i];
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign temp_ok      = filt[0];
  assign batt_present = filt[1];
  assign therm_off    = filt[2];

  a_r2_hot_set: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld && code < HOT_C |=> hot_lat);
  a_r3_hot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hot_lat && sample_vld && code < HOT_REL |=> hot_lat);
  a_r4_cold_set: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld && code > COLD_C |=> cold_lat);
  a_r5_cold_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cold_lat && sample_vld && code > COLD_REL |=> cold_lat);
  a_r8_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_tick |=> $stable({temp_ok, batt_present, therm_off}));
  a_r9_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> $stable(hot_lat) && $stable(cold_lat));

endmodule

// File: tb/sim_batt_therm_qual.sv
module sim_batt_therm_qual;
  logic clk = 1'b0, rst_n = 1'b0, sample_vld = 1'b0, ms_tick = 1'b0;
  logic [9:0] code = '0;
  logic temp_ok, batt_present, therm_off;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  batt_therm_qual u0 (.clk, .rst_n, .sample_vld, .code, .ms_tick,
                      .temp_ok, .batt_present, .therm_off);

  task automatic chk(string req, logic [2:0] exp);
    total++;
    if ({temp_ok, batt_present, therm_off} !== exp) begin
      bad++;
      $display("FAIL %s ok/pres/off actual=%b expected=%b", req,
               {temp_ok, batt_present, therm_off}, exp);
    end
  endtask

  task automatic put(input logic [9:0] c);
    @(negedge clk); code = c; sample_vld = 1'b1;
    @(negedge clk); sample_vld = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); ms_tick = 1'b1;
      @(negedge clk); ms_tick = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 3'b000);
    rst_n = 1'b1;
    ticks(20);
    chk("R1 no sample yet", 3'b000);
    put(512); ticks(11);
    chk("R1 before interval", 3'b000);
    ticks(1);
    chk("R8 first accept", 3'b110);
  endtask

  task automatic t_hot;
    put(300); ticks(12);
    chk("R2 too hot", 3'b010);
    put(380); ticks(12);
    chk("R3 inside band", 3'b010);
    put(400); ticks(12);
    chk("R3 released", 3'b110);
  endtask

  task automatic t_cold;
    put(800); ticks(12);
    chk("R4 too cold", 3'b010);
    put(750); ticks(12);
    chk("R5 inside band", 3'b010);
    put(720); ticks(12);
    chk("R5 released", 3'b110);
  endtask

  task automatic t_gone;
    put(1000); ticks(12);
    chk("R6 removed", 3'b000);
    put(900); ticks(12);
    chk("R6 present still cold", 3'b010);
    put(512); ticks(12);
    chk("R6 back in range", 3'b110);
  endtask

  task automatic t_off;
    put(20); ticks(12);
    chk("R7 disabled forces ok", 3'b111);
    put(512); ticks(12);
    chk("R7 re-enabled", 3'b110);
  endtask

  task automatic t_glitch;
    put(300); ticks(6); put(512); ticks(12);
    chk("R8 short excursion ignored", 3'b110);
    put(300); ticks(8); put(512); put(300); ticks(11);
    chk("R8 count restarted", 3'b110);
    ticks(1);
    chk("R8 accepted after restart", 3'b010);
  endtask

  task automatic t_novld;
    @(negedge clk); code = 10'd512;
    ticks(12);
    chk("R9 code without strobe", 3'b010);
  endtask

  initial begin
    t_reset; t_hot; t_cold; t_gone; t_off; t_glitch; t_novld;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule